// File: doc/BRIEF.md
# Ethernet Receive Traffic Monitor

This block listens to a 64-bit receive beat stream. Each beat carries a valid flag, start and end markers, an empty count for the final beat, and an error flag. The error flag reports a failed frame check and is produced upstream. The monitor keeps four tallies:

- frames received cleanly;
- frames received with a check error;
- a 64-bit running total of received bytes;
- a 64-bit count of the clock cycles between the first frame start and the frame that brings the number of finished frames up to a programmed target.

Software programs the target through a word-addressed 32-bit register port and reads the tallies back through the same port. Software can also clear all tallies with a single write. Each 64-bit value is read as two words. Reading the low word captures the high word at that moment, so the pair read back belongs together even while traffic keeps moving.

Top module: `rx_traffic_monitor`

## Requirements
- R1: After reset the target register (offset 0x00) reads all ones. Every tally reads zero, and the control/status word (0x1C) reads zero.
- R2: A valid beat with the end marker set and the error flag low adds one to the clean-frame tally (0x04).
- R3: A valid beat with the end marker set and the error flag high adds one to the error-frame tally (0x08). The error flag is ignored on beats without the end marker.
- R4: The byte total (low word 0x0C, high word 0x10) grows by the beat width (8) for each valid beat without the end marker. It grows by 8 minus the empty field for a valid beat with the end marker. The empty field of a non-final beat is ignored. Beats with valid low change nothing.
- R5: The cycle tally (low word 0x14, high word 0x18) stays zero until the first valid start beat after reset or clear. From then on it counts every clock, the start beat's clock and the completing end beat's clock included, so a single-beat frame meeting a target of 1 gives 1.
- R6: When a valid end beat makes clean plus error frames equal the target, the cycle tally stops and bit 1 of the control/status word (done) reads 1. Both hold until a clear.
- R7: Writing the control/status word with bit 0 set zeroes all tallies, the captured high words, the done bit and the start condition. It leaves the target register unchanged. A write with bit 0 low clears nothing.
- R8: Reading 0x0C or 0x14 captures the matching high word. A later read of 0x10 or 0x18 returns the captured value even if the live counter has since carried into its high half.
- R9: Read data appears on the cycle after the read strobe. Writes to the read-only offsets 0x04 to 0x18 change no tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | First beat of a frame |
| rx_eop | input | 1 | Last beat of a frame |
| rx_empty | input | 3 | Unused bytes in the last beat |
| rx_err | input | 1 | Frame check error, sampled on the last beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset, bits 4:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |

## Verification
The bench runs a narrow 8-bit register configuration so that the 16-bit byte total carries into its high half within a few hundred bytes. This lets the captured-high-word rule be caught: a design that returns the live high half reads one too many after the carry.

The bench sweeps every empty value across one-, two- and three-beat frames. Idle beats carrying stray markers sit between data beats. Wrong arithmetic on the last beat, or counting unqualified beats, shows up as a byte total that is off.

The single-beat frame against a target of 1 tests the inclusive cycle window, where an off-by-one design reports 0 or 2. Frames sent after the target is reached would move a cycle tally that fails to freeze. A control write with bit 0 low would empty the counters of a design that decodes the clear loosely.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int REG_ADDR_W     = 5;
  localparam int CTRL_CLEAR_BIT = 0;
  localparam int CTRL_DONE_BIT  = 1;

  typedef enum logic [2:0] {
    IDX_TARGET  = 3'd0,
    IDX_GOOD    = 3'd1,
    IDX_BAD     = 3'd2,
    IDX_BYTE_LO = 3'd3,
    IDX_BYTE_HI = 3'd4,
    IDX_CYC_LO  = 3'd5,
    IDX_CYC_HI  = 3'd6,
    IDX_CTRL    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/rxm_frame_tally.sv
module rxm_frame_tally #(
  parameter int CNT_W      = 32,
  parameter int WIDE_W     = 64,
  parameter int BEAT_BYTES = 8,
  parameter int EMPTY_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               valid,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic               err,
  output logic [CNT_W-1:0]   good_cnt,
  output logic [CNT_W-1:0]   bad_cnt,
  output logic [WIDE_W-1:0]  byte_cnt
);
  localparam logic [WIDE_W-1:0] FULL_BEAT = WIDE_W'(BEAT_BYTES);

  logic [CNT_W-1:0]  good_q, good_d, bad_q, bad_d;
  logic [WIDE_W-1:0] byte_q, byte_d, beat_bytes;
  logic              upd_en;

  assign beat_bytes = eop ? (FULL_BEAT - WIDE_W'(empty)) : FULL_BEAT;
  assign upd_en     = clear | valid;

  always_comb begin
    good_d = good_q;
    bad_d  = bad_q;
    byte_d = byte_q;
    if (clear) begin
      good_d = '0;
      bad_d  = '0;
      byte_d = '0;
    end else if (valid) begin
      byte_d = byte_q + beat_bytes;
      if (eop) begin
        if (err) bad_d  = bad_q + CNT_W'(1);
        else     good_d = good_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
      byte_q <= '0;
    end else if (upd_en) begin
      good_q <= good_d;
      bad_q  <= bad_d;
      byte_q <= byte_d;
    end
  end

  assign good_cnt = good_q;
  assign bad_cnt  = bad_q;
  assign byte_cnt = byte_q;
endmodule

// File: rtl/rxm_window_timer.sv
module rxm_window_timer #(
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sop_beat,
  input  logic              eop_beat,
  input  logic [CNT_W-1:0]  frame_total,
  input  logic [CNT_W-1:0]  target,
  output logic [WIDE_W-1:0] cyc_cnt,
  output logic              done
);
  logic [WIDE_W-1:0] cyc_q, cyc_d;
  logic              run_q, run_d, done_q, done_d;
  logic              active, hit, upd_en;

  assign hit    = eop_beat && (({1'b0, frame_total} + (CNT_W+1)'(1)) == {1'b0, target});
  assign active = !done_q && (run_q || sop_beat);
  assign upd_en = clear | active | hit;

  always_comb begin
    cyc_d  = cyc_q;
    run_d  = run_q;
    done_d = done_q;
    if (clear) begin
      cyc_d  = '0;
      run_d  = 1'b0;
      done_d = 1'b0;
    end else begin
      if (active) begin
        cyc_d = cyc_q + WIDE_W'(1);
        run_d = 1'b1;
      end
      if (hit) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (upd_en) begin
      cyc_q  <= cyc_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign cyc_cnt = cyc_q;
  assign done    = done_q;
endmodule

// File: rtl/rxm_csr.sv
module rxm_csr
  import rxm_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int WIDE_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic [REG_W-1:0]      good_cnt,
  input  logic [REG_W-1:0]      bad_cnt,
  input  logic [WIDE_W-1:0]     byte_cnt,
  input  logic [WIDE_W-1:0]     cyc_cnt,
  input  logic                  done,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [REG_W-1:0]      target,
  output logic                  clear
);
  localparam int NWIDE = 2;

  reg_idx_e          idx;
  logic [REG_W-1:0]  target_q;
  logic              target_en, rd_en;
  logic [REG_W-1:0]  rdata_q, rdata_d;
  logic [WIDE_W-1:0] wide_in [NWIDE];
  logic [REG_W-1:0]  snap_q  [NWIDE];
  reg_idx_e          lo_idx  [NWIDE];

  assign idx       = reg_idx_e'(reg_addr[REG_ADDR_W-1:2]);
  assign clear     = reg_wr && (idx == IDX_CTRL) && reg_wdata[CTRL_CLEAR_BIT];
  assign target_en = reg_wr && (idx == IDX_TARGET);
  assign rd_en     = reg_rd;

  assign wide_in[0] = byte_cnt;
  assign wide_in[1] = cyc_cnt;
  assign lo_idx[0]  = IDX_BYTE_LO;
  assign lo_idx[1]  = IDX_CYC_LO;

  for (genvar g = 0; g < NWIDE; g++) begin : g_snap
    logic snap_en;
    assign snap_en = clear || (reg_rd && (idx == lo_idx[g]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[g] <= '0;
      else if (snap_en) snap_q[g] <= clear ? '0 : wide_in[g][WIDE_W-1:REG_W];
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (idx)
      IDX_TARGET:  rdata_d = target_q;
      IDX_GOOD:    rdata_d = good_cnt;
      IDX_BAD:     rdata_d = bad_cnt;
      IDX_BYTE_LO: rdata_d = byte_cnt[REG_W-1:0];
      IDX_BYTE_HI: rdata_d = snap_q[0];
      IDX_CYC_LO:  rdata_d = cyc_cnt[REG_W-1:0];
      IDX_CYC_HI:  rdata_d = snap_q[1];
      IDX_CTRL:    rdata_d[CTRL_DONE_BIT] = done;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= '1;
    else if (target_en) target_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign target    = target_q;
endmodule

// File: rtl/rx_traffic_monitor.sv
module rx_traffic_monitor
  import rxm_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int BEAT_BYTES = 8,
  localparam int EMPTY_W   = $clog2(BEAT_BYTES),
  localparam int WIDE_W    = 2 * REG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic                  rx_sop,
  input  logic                  rx_eop,
  input  logic [EMPTY_W-1:0]    rx_empty,
  input  logic                  rx_err,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata
);
  logic              rst_meta_q, rst_sync_q;
  logic              sop_beat, eop_beat, clear, done;
  logic [REG_W-1:0]  good_cnt, bad_cnt, frame_total, target;
  logic [WIDE_W-1:0] byte_cnt, cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign sop_beat    = rx_valid && rx_sop;
  assign eop_beat    = rx_valid && rx_eop;
  assign frame_total = good_cnt + bad_cnt;

  rxm_frame_tally #(
    .CNT_W(REG_W), .WIDE_W(WIDE_W), .BEAT_BYTES(BEAT_BYTES), .EMPTY_W(EMPTY_W)
  ) u_tally (
    .clk(clk), .rst_n(rst_sync_q), .clear(clear),
    .valid(rx_valid), .eop(rx_eop), .empty(rx_empty), .err(rx_err),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt), .byte_cnt(byte_cnt)
  );

  rxm_window_timer #(.CNT_W(REG_W), .WIDE_W(WIDE_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .clear(clear),
    .sop_beat(sop_beat), .eop_beat(eop_beat),
    .frame_total(frame_total), .target(target),
    .cyc_cnt(cyc_cnt), .done(done)
  );

  rxm_csr #(.REG_W(REG_W), .WIDE_W(WIDE_W)) u_csr (
    .clk(clk), .rst_n(rst_sync_q),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt), .byte_cnt(byte_cnt),
    .cyc_cnt(cyc_cnt), .done(done),
    .reg_rdata(reg_rdata), .target(target), .clear(clear)
  );
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int REG_W  = 32,
  parameter int WIDE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_err,
  input logic              sop_beat,
  input logic              eop_beat,
  input logic              clear,
  input logic              done,
  input logic [REG_W-1:0]  good_cnt,
  input logic [REG_W-1:0]  bad_cnt,
  input logic [WIDE_W-1:0] byte_cnt,
  input logic [WIDE_W-1:0] cyc_cnt
);
  a_r2_good_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_beat && !rx_err && !clear) |=> ((good_cnt - $past(good_cnt)) == REG_W'(1)));

  a_r3_bad_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_beat && rx_err && !clear) |=> ((bad_cnt - $past(bad_cnt)) == REG_W'(1)));

  a_r4_idle_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !clear) |=> $stable(byte_cnt));

  a_r5_wait_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && (cyc_cnt == '0) && !sop_beat && !clear) |=> (cyc_cnt == '0));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> ($stable(cyc_cnt) && done));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((good_cnt == '0) && (bad_cnt == '0) && (byte_cnt == '0)
               && (cyc_cnt == '0) && !done));
endmodule

bind rx_traffic_monitor rxm_checker #(.REG_W(REG_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_q), .rx_valid(rx_valid), .rx_err(rx_err),
  .sop_beat(sop_beat), .eop_beat(eop_beat), .clear(clear), .done(done),
  .good_cnt(good_cnt), .bad_cnt(bad_cnt), .byte_cnt(byte_cnt), .cyc_cnt(cyc_cnt)
);

// File: tb/tb_rx_traffic_monitor.sv
module tb_rx_traffic_monitor;
  localparam int TW = 8;
  localparam logic [4:0] A_TGT = 5'h00, A_GOOD = 5'h04, A_BAD = 5'h08,
    A_BLO = 5'h0C, A_BHI = 5'h10, A_CLO = 5'h14, A_CHI = 5'h18, A_CTRL = 5'h1C;

  logic          clk, rst_n;
  logic          rx_valid, rx_sop, rx_eop, rx_err;
  logic [2:0]    rx_empty;
  logic          reg_wr, reg_rd;
  logic [4:0]    reg_addr;
  logic [TW-1:0] reg_wdata, reg_rdata;

  rx_traffic_monitor #(.REG_W(TW), .BEAT_BYTES(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_empty(rx_empty), .rx_err(rx_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc_now = 0;
  bit finished = 0;
  always @(posedge clk) cyc_now <= cyc_now + 1;

  int m_good, m_bad, m_bytes, m_tgt, m_start, m_end;
  bit m_started, m_done;

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic model_clear();
    m_good = 0; m_bad = 0; m_bytes = 0; m_started = 0; m_done = 0;
    m_start = 0; m_end = 0;
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = TW'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
  endtask

  task automatic idle_garbage();
    rx_valid = 1'b0; rx_sop = 1'b1; rx_eop = 1'b1; rx_empty = 3'd3; rx_err = 1'b1;
  endtask

  task automatic send_frame(int nb, int e, bit err, bit gaps);
    for (int b = 0; b < nb; b++) begin
      bit last;
      int idx;
      last = (b == nb - 1);
      @(negedge clk);
      idx = cyc_now + 1;
      rx_valid = 1'b1; rx_sop = (b == 0); rx_eop = last;
      rx_empty = last ? 3'(e) : 3'(b + 5); rx_err = err;
      if (b == 0 && !m_started && !m_done) begin m_started = 1; m_start = idx; end
      m_bytes = (m_bytes + (last ? 8 - e : 8)) & 16'hFFFF;
      if (last) begin
        if (err) m_bad++; else m_good++;
        if (!m_done && ((m_good + m_bad) == m_tgt)) begin m_done = 1; m_end = idx; end
      end
      if (gaps) begin @(negedge clk); idle_garbage(); end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_empty = 3'd0; rx_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int v, hi_snap;
    rst_n = 1'b0; rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_empty = 0; rx_err = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    model_clear(); m_tgt = 255;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    rd(A_TGT, v);  check("R1 target", v, 'hFF);
    rd(A_GOOD, v); check("R1 good", v, 0);
    rd(A_BAD, v);  check("R1 bad", v, 0);
    rd(A_BLO, v);  check("R1 bytes lo", v, 0);
    rd(A_BHI, v);  check("R1 bytes hi", v, 0);
    rd(A_CLO, v);  check("R1 cycles lo", v, 0);
    rd(A_CHI, v);  check("R1 cycles hi", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);

    // R2 R3 R4 R5 R6: sweep of lengths and empties, target reached mid-run
    wr(A_TGT, 20); m_tgt = 20;
    for (int nb = 1; nb <= 3; nb++)
      for (int e = 0; e < 8; e++)
        send_frame(nb, e, ((nb * 8 + e) % 5) == 0, e[0]);
    repeat (3) @(negedge clk);
    rd(A_GOOD, v); check("R2 good tally", v, m_good);
    rd(A_BAD, v);  check("R3 bad tally", v, m_bad);
    rd(A_BLO, v);  check("R4 bytes lo", v, m_bytes & 'hFF);
    rd(A_BHI, v);  check("R4 bytes hi", v, m_bytes >> 8);
    rd(A_CLO, v);  check("R6 cycles lo frozen", v, (m_end - m_start + 1) & 'hFF);
    rd(A_CHI, v);  check("R6 cycles hi frozen", v, (m_end - m_start + 1) >> 8);
    rd(A_CTRL, v); check("R6 done", v, 2);

    // R8: high half captured at low read survives a carry
    rd(A_BLO, v); check("R8 bytes lo", v, m_bytes & 'hFF);
    hi_snap = m_bytes >> 8;
    for (int k = 0; k < 5; k++) send_frame(8, 0, 1'b0, 1'b0);
    rd(A_BHI, v); check("R8 bytes hi captured", v, hi_snap);
    rd(A_BLO, v); check("R8 bytes lo fresh", v, m_bytes & 'hFF);
    rd(A_BHI, v); check("R8 bytes hi fresh", v, m_bytes >> 8);
    rd(A_CLO, v); check("R6 cycles still frozen", v, (m_end - m_start + 1) & 'hFF);

    // R9: writes to read-only words, R7: ctrl write without bit 0
    wr(A_GOOD, 'h55); wr(A_BLO, 'h11); wr(A_CTRL, 2);
    rd(A_GOOD, v); check("R9 good untouched", v, m_good & 'hFF);
    rd(A_BLO, v);  check("R9 bytes untouched", v, m_bytes & 'hFF);
    rd(A_BAD, v);  check("R7 no clear with bit0 low", v, m_bad);

    // R7: clear
    wr(A_CTRL, 1); model_clear();
    rd(A_GOOD, v); check("R7 good zero", v, 0);
    rd(A_BAD, v);  check("R7 bad zero", v, 0);
    rd(A_BLO, v);  check("R7 bytes lo zero", v, 0);
    rd(A_BHI, v);  check("R7 bytes hi zero", v, 0);
    rd(A_CLO, v);  check("R7 cycles zero", v, 0);
    rd(A_CTRL, v); check("R7 done zero", v, 0);
    rd(A_TGT, v);  check("R7 target kept", v, 20);

    // R5: single-beat frame against target 1
    wr(A_TGT, 1); m_tgt = 1;
    repeat (5) @(negedge clk);
    rd(A_CLO, v); check("R5 idle before start", v, 0);
    send_frame(1, 5, 1'b1, 1'b0);
    rd(A_CLO, v);  check("R5 single beat window", v, 1);
    rd(A_BAD, v);  check("R3 single bad frame", v, 1);
    rd(A_BLO, v);  check("R4 single beat bytes", v, 3);
    rd(A_CTRL, v); check("R6 done single", v, 2);

    // R6: done only at the target
    wr(A_CTRL, 1); model_clear();
    wr(A_TGT, 3); m_tgt = 3;
    send_frame(2, 1, 1'b0, 1'b1);
    send_frame(3, 7, 1'b1, 1'b0);
    rd(A_CTRL, v); check("R6 not done early", v, 0);
    send_frame(2, 0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    rd(A_CTRL, v); check("R6 done at target", v, 2);
    rd(A_CLO, v);  check("R5 window cycles", v, (m_end - m_start + 1) & 'hFF);
    rd(A_GOOD, v); check("R2 good after clear", v, 2);

    summary();
  end
endmodule